// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block turns digitized supply-monitor flags and the sensed level of a shared, open-drain reset line into one reset decision for the chip. While that decision is active, it drives the reset line low through a pull-down enable. It also holds the internal active-low reset low, so the logic that drives motors and regulators, and the serial register, returns to its default state. The reset is released only after the supervised supplies have stayed healthy for a long, fixed settling interval. A supply loss brings reset back with no such wait.

Three inputs watch the supplies. The logic supply has a single comparator flag. A persistence filter ignores dips on it that are shorter than a short window. The main supply has two comparator flags, a high one and a low one. A set/reset flag latches them, so the gap between the two thresholds gives hysteresis. Any other device on the board can force a reset by holding the shared line low for longer than a minimum width. The supervisor's own pull-down is masked from that detector, so the block never triggers itself. All intervals are clock-cycle counts set by parameters.

Top module: `supply_reset_gen`

## Requirements
- R1: In reset (rst_ni low) and right after it, the block holds reset: sys_rst_no is 0 and pin_pull_o is 1. At all times pin_pull_o equals the inverse of sys_rst_no.
- R2: A release needs the main supply marked good and no external request. Take the first clock edge at which vcc_ok_i is sampled 1 as edge e. Reset is then still held after edge e+REL_CYC-1 and released after edge e+REL_CYC.
- R3: If vcc_ok_i is sampled 0 on DEG_CYC consecutive edges, reset is asserted after the next edge.
- R4: A run of vcc_ok_i lows shorter than DEG_CYC samples has no effect on the outputs.
- R5: The main supply is marked good when vs_hi_i is 1 and vs_lo_i is 0. It is marked bad when vs_lo_i is 1. While both flags are 0 it keeps its last state, in either direction.
- R6: When vs_lo_i is sampled 1 at edge k while reset is released, reset is asserted after edge k+1, with no filtering.
- R7: If a filtered fault reappears while the release count is running, the count starts again from zero. The release then comes REL_CYC edges after the fault clears.
- R8: A low on pin_sense_i that lasts fewer than EXT_CYC samples while the block is not pulling has no effect.
- R9: If pin_sense_i is sampled 0 on EXT_CYC consecutive edges while the block is not pulling, reset is asserted after the next edge. It is released REL_CYC+1 edges after that assertion edge.
- R10: A low on the line caused by the block's own pull-down is never taken as an external request, so a release is not followed by a new reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Supervisor clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the supervisor logic |
| vcc_ok_i | input | 1 | Logic supply above its threshold |
| vs_hi_i | input | 1 | Main supply above its upper threshold |
| vs_lo_i | input | 1 | Main supply below its lower threshold |
| pin_sense_i | input | 1 | Sensed level of the shared reset line |
| pin_pull_o | output | 1 | Enable of the open-drain pull-down on the reset line |
| sys_rst_no | output | 1 | Active-low reset to the internal logic |

## Verification
Some properties are checked by assertions on every cycle. A fault always forces the hold on the next edge. A release happens only when the counter is at its last value. A fault resets the counter. A gap in the trigger clears each persistence filter. The low flag clears the main-supply flag, and the flag is held in the dead band. The block's own pull-down always clears the external-request detector. The exact release cycle counted from the first good sample, the rejection of short supply dips and short external pulses, and the restart of the count on a fault that returns late can only be shown by the bench scenarios. The bench models the wired line with a pull-up and compares both outputs against cycle-stamped expectations.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

  typedef struct packed {
    logic vcc_low;
    logic vs_low;
    logic ext_low;
  } fault_t;

  // width of a counter that spans 0 .. n-1
  function automatic int cnt_w(int n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rst_sup_vs_hyst.sv
module rst_sup_vs_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_hi_i,
  input  logic below_lo_i,
  output logic ok_o
);

  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ok_q <= 1'b0;
    else if (below_lo_i) ok_q <= 1'b0;
    else if (above_hi_i) ok_q <= 1'b1;
  end

  assign ok_o = ok_q;

  a_r5_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    below_lo_i |=> !ok_o);

  a_r5_band_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!below_lo_i && !above_hi_i) |=> $stable(ok_o));

endmodule

// File: rtl/rst_sup_persist.sv
module rst_sup_persist
  import rst_sup_pkg::*;
#(
  parameter int   LEN     = 4,
  parameter logic RST_HIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic hit_o
);

  localparam int W = cnt_w(LEN);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;
  logic         hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_q <= RST_HIT;
    end else if (!trig_i) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (!hit_q) begin
      if (cnt_q == LAST) hit_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = hit_q;

  a_r4_gap_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> !hit_o);

  a_r3_hit_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> ($past(trig_i) && $past(cnt_q) == LAST));

endmodule

// File: rtl/rst_sup_release.sv
module rst_sup_release
  import rst_sup_pkg::*;
#(
  parameter int REL_CYC = 100_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  output logic hold_o
);

  localparam int W = cnt_w(REL_CYC);
  localparam logic [W-1:0] LAST = W'(REL_CYC - 1);

  logic [W-1:0] cnt_q;
  logic         hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (fault_i) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (hold_q) begin
      if (cnt_q == LAST) hold_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign hold_o = hold_q;

  a_r1_fault_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> hold_o);

  a_r7_fault_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (cnt_q == '0));

  a_r2_release_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> ($past(cnt_q) == LAST && !$past(fault_i)));

endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
  import rst_sup_pkg::*;
#(
  parameter int REL_CYC = 100_000,
  parameter int DEG_CYC = 20,
  parameter int EXT_CYC = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic vs_hi_i,
  input  logic vs_lo_i,
  input  logic pin_sense_i,
  output logic pin_pull_o,
  output logic sys_rst_no
);

  fault_t flt;
  logic   vs_ok;
  logic   vcc_low;
  logic   ext_low;
  logic   ext_trig;
  logic   hold;

  rst_sup_vs_hyst u_vs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .above_hi_i (vs_hi_i),
    .below_lo_i (vs_lo_i),
    .ok_o       (vs_ok)
  );

  // supply starts out considered low until proven otherwise
  rst_sup_persist #(.LEN(DEG_CYC), .RST_HIT(1'b1)) u_vcc_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (!vcc_ok_i),
    .hit_o  (vcc_low)
  );

  // own pull-down masked so a held line never re-arms the detector
  assign ext_trig = !pin_sense_i && !hold;

  rst_sup_persist #(.LEN(EXT_CYC), .RST_HIT(1'b0)) u_ext_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (ext_trig),
    .hit_o  (ext_low)
  );

  assign flt.vcc_low = vcc_low;
  assign flt.vs_low  = !vs_ok;
  assign flt.ext_low = ext_low;

  rst_sup_release #(.REL_CYC(REL_CYC)) u_rel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (flt.vcc_low | flt.vs_low | flt.ext_low),
    .hold_o  (hold)
  );

  assign pin_pull_o = hold;
  assign sys_rst_no = !hold;

  a_r6_vs_bad_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vs_ok |=> pin_pull_o);

  a_r3_vcc_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_low |=> !sys_rst_no);

  a_r9_ext_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_low |=> pin_pull_o);

  a_r10_self_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_pull_o |=> !ext_low);

endmodule

// File: tb/supply_reset_gen_tb.sv
`timescale 1ns/1ps
module supply_reset_gen_tb;

  localparam int REL = 40;
  localparam int DEG = 4;
  localparam int EXT = 6;

  typedef struct {
    int    at;
    bit    hold;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b0;
  logic vs_hi = 1'b0;
  logic vs_lo = 1'b1;
  logic ext_drv = 1'b0;
  logic pin;
  logic pull;
  logic sys_rst_n;

  int    cyc = 0;
  int    checks = 0;
  int    errs = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  // wired line: pull-up, low when either side pulls
  assign pin = !(pull || ext_drv);

  supply_reset_gen #(.REL_CYC(REL), .DEG_CYC(DEG), .EXT_CYC(EXT)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vcc_ok_i    (vcc_ok),
    .vs_hi_i     (vs_hi),
    .vs_lo_i     (vs_lo),
    .pin_sense_i (pin),
    .pin_pull_o  (pull),
    .sys_rst_no  (sys_rst_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int off, input bit hold, input string req);
    item_t it;
    it.at = cyc + off;
    it.hold = hold;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // monitor: compare outputs at the stamped cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (sys_rst_n !== !it.hold || pull !== it.hold) begin
        errs++;
        $display("FAIL %s at cycle %0d: sys_rst_no=%b pin_pull_o=%b, expected sys_rst_no=%b pin_pull_o=%b",
                 it.req, cyc, sys_rst_n, pull, !it.hold, it.hold);
      end
    end
  end

  initial begin
    int n;
    int p;
    repeat (3) @(negedge clk);
    checks++;
    if (sys_rst_n !== 1'b0 || pull !== 1'b1) begin
      errs++;
      $display("FAIL R1 in reset: sys_rst_no=%b pin_pull_o=%b, expected 0 1", sys_rst_n, pull);
    end
    rst_n = 1'b1;

    // R5/R1: main supply good, Vcc still low -> stays held
    n = cyc; vs_hi = 1'b1; vs_lo = 1'b0;
    push(2, 1'b1, "R1");
    wait_to(n + 4);

    // R2: release timing from first good Vcc sample
    n = cyc; vcc_ok = 1'b1;
    push(REL, 1'b1, "R2");
    push(REL + 1, 1'b0, "R2");
    push(REL + 20, 1'b0, "R10");
    wait_to(n + REL + 22);

    // R4: short Vcc dip ignored
    n = cyc; vcc_ok = 1'b0;
    for (int k = 1; k <= DEG + 3; k++) push(k, 1'b0, "R4");
    wait_to(n + DEG - 1); vcc_ok = 1'b1;
    wait_to(n + DEG + 5);

    // R3: long Vcc dip asserts
    n = cyc; vcc_ok = 1'b0;
    push(DEG, 1'b0, "R3");
    push(DEG + 1, 1'b1, "R3");
    wait_to(n + DEG + 5);

    // R7: fault reappears during release count
    p = cyc; vcc_ok = 1'b1;
    push(REL + 1, 1'b1, "R7");
    push(10 + DEG + REL, 1'b1, "R7");
    push(11 + DEG + REL, 1'b0, "R7");
    wait_to(p + 10); vcc_ok = 1'b0;
    wait_to(p + 10 + DEG); vcc_ok = 1'b1;
    wait_to(p + 11 + DEG + REL + 5);

    // R5: dead band keeps good state
    n = cyc; vs_hi = 1'b0;
    for (int k = 1; k <= 5; k++) push(k, 1'b0, "R5");
    wait_to(n + 6);

    // R6: low flag asserts at second edge
    n = cyc; vs_lo = 1'b1;
    push(1, 1'b0, "R6");
    push(2, 1'b1, "R6");
    wait_to(n + 3); vs_lo = 1'b0;
    n = cyc;
    push(REL + 10, 1'b1, "R5");
    wait_to(n + REL + 12);
    p = cyc; vs_hi = 1'b1;
    push(REL, 1'b1, "R5");
    push(REL + 1, 1'b0, "R5");
    wait_to(p + REL + 5);

    // R8: short external pulse ignored
    n = cyc; ext_drv = 1'b1;
    for (int k = 1; k <= EXT + 3; k++) push(k, 1'b0, "R8");
    wait_to(n + EXT - 1); ext_drv = 1'b0;
    wait_to(n + EXT + 5);

    // R9/R10: external reset, full delay, no self retrigger
    n = cyc; ext_drv = 1'b1;
    push(EXT, 1'b0, "R9");
    push(EXT + 1, 1'b1, "R9");
    push(EXT + 1 + REL, 1'b1, "R9");
    push(EXT + 2 + REL, 1'b0, "R9");
    push(EXT + 32 + REL, 1'b0, "R10");
    wait_to(n + EXT + 3); ext_drv = 1'b0;
    wait_to(n + EXT + REL + 36);

    while (sb_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule